// File: doc/BRIEF.md
# Serial Audio Transmit Port

This block is the transmit half of a two-channel serial audio port. Software-side logic pushes 32-bit sample words into an eight-entry FIFO. The port shifts them out on a serial data line, alongside a bit clock and a word-select line that it generates itself. The bit clock is derived from the block clock through a selectable divider that offers power-of-two ratios and also the ratios 6, 12, 24, 48 and 96.

Each frame has two halves, told apart by the word-select level. Each half carries one to four slots, and each slot consumes one FIFO word. The sample width and the slot width are chosen independently. Samples are sent MSB first, left-justified in the slot, with zero padding after them. The FIFO raises a refill request when its free space reaches a selected threshold. An empty FIFO during transmission produces silent slots and sets a sticky underflow flag. A keep-alive option holds the clocks running while transmission is off.

The block clock runs at twice the oversampling rate. A bit clock period therefore spans two times the divide ratio in block clock cycles. All configuration inputs are expected to stay static while the port runs.

Top module: `audio_tx_port`

## Requirements
- R1: The bit clock period is 2×M block clock cycles, with each level held for M cycles. M comes from `div_sel` as follows: 0 gives 1; 1 to 7 give 2, 4, 8, 16, 32, 64 and 128; 8 to 12 give 6, 12, 24, 48 and 96.
- R2: Serial data and word-select change on the edge into level `sck_launch_rise`. They are read on the edge into the opposite level.
- R3: In the first half of a frame, word-select equals `ws_first_high`; in the second half it is the inverse. Word-select moves during the last bit period before a half begins.
- R4: `dwl_sel` codes 0 to 6 select 8, 16, 18, 20, 22, 24 or 32 data bits, taken from the low bits of the FIFO word. They are sent MSB first from the slot's first bit period. Bits past the data width are zero, and a slot shorter than the data truncates it.
- R5: `slot_sel` codes 0 to 7 select a slot of 8, 16, 24, 32, 48, 64, 128 or 256 bit periods. `chan_sel` codes 0 to 3 select 1 to 4 slots per half. FIFO words fill the slots in push order, and the first bit period after starting from a stopped port is bit 0 of slot 0.
- R6: The FIFO holds 8 words. `fifo_full` is high while it holds 8, and a push while full is dropped.
- R7: `fifo_req` is high while the free entries are at least 7, 6, 4 or 2, for `req_sel` codes 0 to 3 respectively.
- R8: While transmitting, a slot that starts with the FIFO empty carries all zeros and sets `underflow`. The flag stays set until reset.
- R9: With `tx_enable` low and `clk_keepalive` high, the bit clock and word-select run, the data line stays 0 and no FIFO word is consumed. With both low, the port stops: the bit clock rests at the inverse of `sck_launch_rise`, word-select rests at `ws_first_high` and the data line is 0.
- R10: After reset the FIFO is empty, `fifo_full` and `underflow` are 0, `fifo_req` is 1, and the serial outputs sit at their stopped levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the oversampling rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit FIFO data |
| clk_keepalive | input | 1 | Keep bit clock and word-select running while not transmitting |
| dwl_sel | input | 3 | Data width code |
| slot_sel | input | 3 | Slot width code |
| chan_sel | input | 2 | Slots per half-frame minus one |
| div_sel | input | 4 | Bit clock divide code |
| sck_launch_rise | input | 1 | Level entered by the launching bit clock edge |
| ws_first_high | input | 1 | Word-select level of the first half-frame |
| req_sel | input | 2 | Free-space request threshold code |
| push_valid | input | 1 | Write one word into the FIFO |
| push_data | input | 32 | Word to write |
| fifo_full | output | 1 | FIFO holds 8 words |
| fifo_req | output | 1 | Free space at or above threshold |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data |
| underflow | output | 1 | Sticky empty-at-slot-start flag |

## Verification
The bench acts as a receiver. It decodes every bit on the read edge and compares it with a frame model built from the pushed words. A port that counted the slot or frame off by one bit, or moved word-select together with the first data bit rather than one period earlier, would fail on every half boundary. The bench also goes after the odd divide ratios and the 128 ratio, a 256-bit slot carrying a 24-bit sample, a 32-bit sample in an 8-bit slot, and four slots per half. A wrong ratio table or a broken truncation or padding would show as bad bit periods or stray ones. Further cases are a ninth push into a full FIFO, underruns mid-frame, and keep-alive running with words already queued. A design that consumed words while idle would then send them out of order or lose them.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  // bit clock divide ratio for a divide code
  function automatic int unsigned div_ratio(input logic [3:0] code);
    if (code == 4'd0)       return 1;
    else if (code <= 4'd7)  return 1 << code;
    else if (code <= 4'd12) return 3 << (code - 4'd7);
    else                    return 1;
  endfunction

  // data width in bits for a data width code
  function automatic int unsigned data_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 18;
      3'd3:    return 20;
      3'd4:    return 22;
      3'd5:    return 24;
      default: return 32;
    endcase
  endfunction

  // slot width in bit periods for a slot code
  function automatic int unsigned slot_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 24;
      3'd3:    return 32;
      3'd4:    return 48;
      3'd5:    return 64;
      3'd6:    return 128;
      default: return 256;
    endcase
  endfunction

  // free entries needed to raise the refill request
  function automatic int unsigned free_needed(input logic [1:0] code);
    case (code)
      2'd0:    return 7;
      2'd1:    return 6;
      2'd2:    return 4;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter  int WIDTH = 32,
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic [CW-1:0]    free_thr,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full_q,
  output logic             req_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_n;
  logic             push_ok;

  assign push_ok = push && (count != DEPTH_C);
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  always_comb begin
    count_n = count + CW'(push_ok) - CW'(pop);
  end

  // storage written without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full_q <= 1'b0;
      req_q  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      count  <= count_n;
      full_q <= (count_n == DEPTH_C);
      req_q  <= ((DEPTH_C - count_n) >= free_thr);
    end
  end
endmodule

// File: rtl/audio_tx_bitclk.sv
module audio_tx_bitclk #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               launch_rise,
  input  logic [RATIO_W-1:0] ratio,
  output logic               launch,
  output logic               fresh,
  output logic               sck_o
);
  localparam int PH_W = RATIO_W + 1;

  logic [PH_W-1:0] phase, half_last, full_last;
  logic            running, mid;

  assign half_last = {1'b0, ratio} - 1'b1;
  assign full_last = {ratio, 1'b0} - 1'b1;
  assign fresh     = ~running;
  assign launch    = run & (~running | (phase == full_last));
  assign mid       = run & running & (phase == half_last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      running <= 1'b0;
      phase   <= '0;
      sck_o   <= ~launch_rise;
    end else begin
      running <= 1'b1;
      if (launch) begin
        phase <= '0;
        sck_o <= launch_rise;
      end else begin
        phase <= phase + 1'b1;
        if (mid) sck_o <= ~launch_rise;
      end
    end
  end
endmodule

// File: rtl/audio_tx_framer.sv
module audio_tx_framer #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 9,
  parameter int DL_W   = 6,
  parameter int CH_W   = 3,
  parameter int SL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              launch,
  input  logic              fresh,
  input  logic              enable,
  input  logic              first_high,
  input  logic [DL_W-1:0]   dwl,
  input  logic [LEN_W-1:0]  swl,
  input  logic [CH_W-1:0]   chans,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              pop,
  output logic              ws_o,
  output logic              sd_o,
  output logic              uf_o
);
  logic [LEN_W-1:0]  k, k_n, k_last;
  logic [SL_W-1:0]   s, s_n, s_a, s_last;
  logic              xmit, xmit_n, load, ws_n;
  logic [WORD_W-1:0] sh, word_n, aligned;
  logic [DL_W-1:0]   shamt;

  assign k_last = swl - 1'b1;
  assign s_last = SL_W'({chans, 1'b0}) - 1'b1;
  assign shamt  = DL_W'(WORD_W) - dwl;

  always_comb begin
    // position of the bit period about to start
    if (fresh) begin
      k_n = '0;
      s_n = '0;
    end else if (k == k_last) begin
      k_n = '0;
      s_n = (s == s_last) ? '0 : s + 1'b1;
    end else begin
      k_n = k + 1'b1;
      s_n = s;
    end
    // word-select follows the slot of the period after it
    if (k_n == k_last) s_a = (s_n == s_last) ? '0 : s_n + 1'b1;
    else               s_a = s_n;
    ws_n    = first_high ^ (s_a >= SL_W'(chans));
    load    = launch && (k_n == '0);
    xmit_n  = ((k_n == '0) && (s_n == '0)) ? enable : xmit;
    pop     = load && xmit_n && !fifo_empty;
    word_n  = (xmit_n && !fifo_empty) ? fifo_data : '0;
    aligned = word_n << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k <= '0; s <= '0; xmit <= 1'b0; sh <= '0;
      ws_o <= first_high; sd_o <= 1'b0; uf_o <= 1'b0;
    end else if (!run) begin
      k <= '0; s <= '0; xmit <= 1'b0; sh <= '0;
      ws_o <= first_high; sd_o <= 1'b0;
    end else if (launch) begin
      k    <= k_n;
      s    <= s_n;
      xmit <= xmit_n;
      ws_o <= ws_n;
      if (load) begin
        sd_o <= aligned[WORD_W-1];
        sh   <= aligned << 1;
        if (xmit_n && fifo_empty) uf_o <= 1'b1;
      end else begin
        sd_o <= sh[WORD_W-1];
        sh   <= sh << 1;
      end
    end
  end
endmodule

// File: rtl/audio_tx_port.sv
module audio_tx_port
  import audio_tx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_RATIO  = 128,
  parameter int MAX_SLOT   = 256,
  parameter int MAX_CHANS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_enable,
  input  logic              clk_keepalive,
  input  logic [2:0]        dwl_sel,
  input  logic [2:0]        slot_sel,
  input  logic [1:0]        chan_sel,
  input  logic [3:0]        div_sel,
  input  logic              sck_launch_rise,
  input  logic              ws_first_high,
  input  logic [1:0]        req_sel,
  input  logic              push_valid,
  input  logic [WORD_W-1:0] push_data,
  output logic              fifo_full,
  output logic              fifo_req,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              underflow
);
  localparam int RATIO_W = $clog2(MAX_RATIO + 1);
  localparam int LEN_W   = $clog2(MAX_SLOT + 1);
  localparam int DL_W    = $clog2(WORD_W + 1);
  localparam int CH_W    = $clog2(MAX_CHANS + 1);
  localparam int SL_W    = $clog2(2 * MAX_CHANS + 1);
  localparam int CW      = $clog2(FIFO_DEPTH + 1);

  logic              run, launch, fresh, pop, fifo_empty;
  logic [WORD_W-1:0] fifo_data;
  logic [RATIO_W-1:0] ratio;
  logic [DL_W-1:0]   dwl;
  logic [LEN_W-1:0]  swl;
  logic [CH_W-1:0]   chans;
  logic [CW-1:0]     free_thr;

  assign run      = tx_enable | clk_keepalive;
  assign ratio    = RATIO_W'(div_ratio(div_sel));
  assign dwl      = DL_W'(data_bits(dwl_sel));
  assign swl      = LEN_W'(slot_bits(slot_sel));
  assign chans    = CH_W'(chan_sel) + 1'b1;
  assign free_thr = CW'(free_needed(req_sel));

  audio_tx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_valid), .push_data(push_data),
    .pop(pop), .free_thr(free_thr), .rd_data(fifo_data),
    .empty(fifo_empty), .full_q(fifo_full), .req_q(fifo_req)
  );

  audio_tx_bitclk #(.RATIO_W(RATIO_W)) u_bitclk (
    .clk(clk), .rst(rst), .run(run), .launch_rise(sck_launch_rise),
    .ratio(ratio), .launch(launch), .fresh(fresh), .sck_o(sck_o)
  );

  audio_tx_framer #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .DL_W(DL_W), .CH_W(CH_W), .SL_W(SL_W)
  ) u_framer (
    .clk(clk), .rst(rst), .run(run), .launch(launch), .fresh(fresh),
    .enable(tx_enable), .first_high(ws_first_high), .dwl(dwl), .swl(swl),
    .chans(chans), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .pop(pop), .ws_o(ws_o), .sd_o(sd_o), .uf_o(underflow)
  );
endmodule

// File: rtl/audio_tx_port_chk.sv
module audio_tx_port_chk (
  input logic clk,
  input logic rst,
  input logic tx_enable,
  input logic clk_keepalive,
  input logic sck_launch_rise,
  input logic fifo_full,
  input logic fifo_req,
  input logic sck_o,
  input logic ws_o,
  input logic sd_o,
  input logic underflow,
  input logic run,
  input logic launch,
  input logic pop
);
  assert_launch_level_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (sck_o == $past(sck_launch_rise)));

  assert_ws_only_at_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !launch) |=> $stable(ws_o));

  assert_sd_only_at_launch_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !launch) |=> $stable(sd_o));

  assert_pop_at_slot_launch_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> launch);

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop) |=> fifo_full);

  assert_no_req_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_req);

  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  assert_stopped_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    (!tx_enable && !clk_keepalive) |=> (!sd_o && (sck_o == !$past(sck_launch_rise))));
endmodule

bind audio_tx_port audio_tx_port_chk u_chk (
  .clk(clk), .rst(rst), .tx_enable(tx_enable), .clk_keepalive(clk_keepalive),
  .sck_launch_rise(sck_launch_rise), .fifo_full(fifo_full), .fifo_req(fifo_req),
  .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .underflow(underflow),
  .run(run), .launch(launch), .pop(pop)
);

// File: tb/test_audio_tx_port.sv
module test_audio_tx_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_enable = 0, clk_keepalive = 0;
  logic [2:0] dwl_sel = 1, slot_sel = 1;
  logic [1:0] chan_sel = 0, req_sel = 0;
  logic [3:0] div_sel = 0;
  logic sck_launch_rise = 0, ws_first_high = 0, push_valid = 0;
  logic [31:0] push_data = 0;
  logic fifo_full, fifo_req, sck_o, ws_o, sd_o, underflow;

  audio_tx_port i_audio_tx_port (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .clk_keepalive(clk_keepalive),
    .dwl_sel(dwl_sel), .slot_sel(slot_sel), .chan_sel(chan_sel), .div_sel(div_sel),
    .sck_launch_rise(sck_launch_rise), .ws_first_high(ws_first_high),
    .req_sel(req_sel), .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_req(fifo_req), .sck_o(sck_o), .ws_o(ws_o),
    .sd_o(sd_o), .underflow(underflow)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] q[$];
  int dwl, swl, chans, nrat, thr;
  bit pol, first, uf_exp;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int e_ratio(int c);
    case (c)
      0: return 1;   1: return 2;   2: return 4;   3: return 8;
      4: return 16;  5: return 32;  6: return 64;  7: return 128;
      8: return 6;   9: return 12;  10: return 24; 11: return 48;
      12: return 96; default: return 1;
    endcase
  endfunction
  function automatic int e_dwl(int c);
    case (c) 0: return 8; 1: return 16; 2: return 18; 3: return 20;
      4: return 22; 5: return 24; default: return 32; endcase
  endfunction
  function automatic int e_swl(int c);
    case (c) 0: return 8; 1: return 16; 2: return 24; 3: return 32;
      4: return 48; 5: return 64; 6: return 128; default: return 256; endcase
  endfunction
  function automatic int e_thr(int c);
    case (c) 0: return 7; 1: return 6; 2: return 4; default: return 2; endcase
  endfunction

  task automatic set_cfg(int dc, int sc, int cc, int vc, bit p, bit f, int rc);
    dwl_sel = 3'(dc); slot_sel = 3'(sc); chan_sel = 2'(cc); div_sel = 4'(vc);
    sck_launch_rise = p; ws_first_high = f; req_sel = 2'(rc);
    dwl = e_dwl(dc); swl = e_swl(sc); chans = cc + 1; nrat = e_ratio(vc);
    pol = p; first = f; thr = e_thr(rc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; tx_enable = 0; clk_keepalive = 0; push_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    q.delete();
    uf_exp = 0;
  endtask

  task automatic push_word(logic [31:0] w);
    push_valid = 1; push_data = w;
    @(negedge clk);
    push_valid = 0;
    if (q.size() < 8) q.push_back(w);
  endtask

  task automatic check_fifo_flags(string req);
    check(fifo_full == (q.size() == 8), "R6", {req, " full"}, fifo_full, q.size() == 8);
    check(fifo_req == ((8 - q.size()) >= thr), "R7", {req, " req"},
          fifo_req, (8 - q.size()) >= thr);
  endtask

  // receiver: decode nbits bit periods and compare with the frame model
  task automatic run_stream(int nbits, bit xmit);
    int b = 0, since = 0, guard = 0, k = 0;
    bit prev, started = 0, e_ws, e_sd;
    logic [31:0] cur = 0;
    @(negedge clk);
    tx_enable = xmit; clk_keepalive = !xmit;
    prev = sck_o;
    while (b < nbits && guard < nbits * 4 * nrat + 50) begin
      @(negedge clk);
      guard++; since++;
      if (sck_o != prev) begin
        if (started) check(since == nrat, "R1", "half period", since, nrat);
        started = 1; since = 0;
        k = b % swl;
        e_ws = first ^ ((((b + 1) / swl) % (2 * chans)) >= chans);
        if (sck_o == pol) begin
          if (k == 0) begin
            if (xmit && q.size() > 0) cur = q.pop_front();
            else begin cur = 0; if (xmit) uf_exp = 1; end
          end
          e_sd = (k < dwl) ? cur[dwl - 1 - k] : 1'b0;
          check(sd_o == e_sd, "R2", "data at launch edge", sd_o, e_sd);
        end else begin
          e_sd = (k < dwl) ? cur[dwl - 1 - k] : 1'b0;
          check(ws_o == e_ws, "R3", "word-select", ws_o, e_ws);
          check(sd_o == e_sd, (k == 0) ? "R5" : "R4", "data bit", sd_o, e_sd);
          b++;
        end
      end
      prev = sck_o;
    end
    check(b == nbits, "R1", "bit periods seen", b, nbits);
    tx_enable = 0; clk_keepalive = 0;
    repeat (2) @(negedge clk);
    check(sd_o == 0 && sck_o == !pol && ws_o == first, "R9", "stopped levels",
          {sck_o, ws_o, sd_o}, {!pol, first, 1'b0});
  endtask

  task automatic trial(int dc, int sc, int cc, int vc, bit p, bit f, int nw, int frames);
    set_cfg(dc, sc, cc, vc, p, f, 1);
    do_reset();
    for (int i = 0; i < nw; i++) push_word($urandom);
    run_stream(frames * 2 * chans * swl, 1);
    check(underflow == uf_exp, "R8", "underflow flag", underflow, uf_exp);
  endtask

  initial begin
    void'($urandom(32'd7133));
    set_cfg(1, 1, 0, 0, 0, 0, 0);
    do_reset();
    @(negedge clk);
    // R10 reset state
    check(sck_o == 1 && ws_o == 0 && sd_o == 0, "R10", "serial outputs",
          {sck_o, ws_o, sd_o}, 3'b100);
    check(!fifo_full && fifo_req && !underflow, "R10", "flags",
          {fifo_full, fifo_req, underflow}, 3'b010);

    // R6 / R7: fill for every threshold code, ninth push dropped
    for (int t = 0; t < 4; t++) begin
      set_cfg(0, 0, 3, 0, 0, 0, t);
      do_reset();
      @(negedge clk);
      check_fifo_flags("empty");
      for (int i = 0; i < 9; i++) begin
        push_word($urandom);
        check_fifo_flags("after push");
      end
    end
    // last fill: 8 slots per frame, 2 frames -> ninth word absent, underflow
    run_stream(2 * 2 * chans * swl, 1);
    check(underflow == 1, "R8", "underflow after drain", underflow, 1);
    push_word(32'h1);
    check(underflow == 1, "R8", "underflow sticky", underflow, 1);

    // directed corner cases
    trial(5, 7, 0, 0, 0, 1, 2, 1);   // 24-bit data in a 256-bit slot
    trial(6, 0, 1, 1, 1, 0, 4, 1);   // 32-bit data truncated to 8-bit slot
    trial(2, 1, 3, 2, 0, 0, 8, 1);   // 18 bits, four slots per half
    for (int v = 8; v <= 12; v++) begin   // odd ratios
      set_cfg(0, 0, 0, v, v[0], 0, 1);
      do_reset();
      push_word(32'hA5); push_word(32'h3C);
      run_stream(16, 1);
    end
    set_cfg(0, 0, 0, 7, 0, 1, 1);          // largest ratio
    do_reset();
    push_word(32'h81); push_word(32'h7E);
    run_stream(16, 1);

    // R9 keep-alive: clocks run, nothing consumed, queued words intact
    set_cfg(1, 1, 0, 1, 0, 0, 1);
    do_reset();
    for (int i = 0; i < 3; i++) push_word($urandom);
    run_stream(40, 0);
    check(underflow == 0, "R9", "no underflow while idle", underflow, 0);
    check_fifo_flags("after keep-alive");
    run_stream(2 * chans * swl, 1);
    check(underflow == 0, "R9", "kept words sent", underflow, 0);

    // random configurations
    for (int r = 0; r < 12; r++) begin
      int vlist[6] = '{0, 1, 2, 3, 8, 9};
      trial($urandom % 7, $urandom % 4, $urandom % 2, vlist[$urandom % 6],
            $urandom % 2, $urandom % 2, $urandom % 9, 2);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule